// File: doc/BRIEF.md
# Image Scaler Step Calculator

This unit turns one image dimension's source and destination lengths into the setting a scaler needs for that dimension. It first screens the pair against fixed limits: the source length must be between 1 and 4096, the destination length between 2 and 1024, and the shrink ratio may not exceed four to one. It then picks a pre-shrink code, the number of times (zero, one or two) the source length is halved before resampling. Last, it computes a 14-bit resampling step in unsigned fixed point with 13 fraction bits, using a restoring divider that settles one quotient bit per clock.

Software or a sequencer starts the unit with a one-cycle `start` pulse, once for the vertical dimension and once for the horizontal one, and waits for a one-cycle `done` pulse. Each good result is written into its half of a 32-bit scaler control word that stays in place between runs. A rejected request raises `err` with `done` and leaves the control word as it was. A step that does not fit in 14 bits is clamped to all ones and flagged with `warn`.

Top module: `scl_step_calc`

## Requirements
- R1: A request whose source length is 0 or greater than 4096 completes with `err` and `done` high together, and `ctrl_word` does not change.
- R2: A request whose destination length is below 2 or greater than 1024 completes with `err` and `done` high, and `ctrl_word` does not change.
- R3: A request whose destination length times four is less than its source length completes with `err` and `done` high, and `ctrl_word` does not change.
- R4: The pre-shrink code `dcode` equals the number of halvings (integer, rounding down) applied to the source length. The unit halves while the length is above 1024 or at least twice the destination length, and stops after two halvings.
- R5: The step equals floor(8192 × (halved length − 1) / (destination length − 1)) when that value is below 16384.
- R6: When that value is 16384 or more, the step is 0x3FFF and `warn` is high in the `done` cycle. `warn` is never high outside a `done` cycle.
- R7: A good result with `axis`=1 (vertical) writes the code to `ctrl_word[31:30]` and the step to `ctrl_word[29:16]`. With `axis`=0 (horizontal) it writes the code to bits 15:14 and the step to bits 13:0. The other half is kept.
- R8: `done` is a one-cycle pulse per request. It comes one cycle after `start` for a rejected request. `busy` is high while a good request is dividing and is never high together with `done`.
- R9: A `start` pulse while `busy` is high is ignored and does not alter the result of the run in progress.
- R10: After reset `ctrl_word` is zero and `done`, `busy`, `err` and `warn` are low.
- R11: A `start` given in the same cycle that `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation with the present inputs |
| axis | input | 1 | 1 = vertical dimension, 0 = horizontal dimension |
| src_len | input | 13 | Source length in pixels or lines |
| dst_len | input | 11 | Destination length in pixels or lines |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (valid with done) |
| warn | output | 1 | Step clamped to 0x3FFF (valid with done) |
| dcode | output | 2 | Pre-shrink code of the last good run |
| step | output | 14 | Resampling step of the last good run |
| ctrl_word | output | 32 | Packed scaler control word |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. The bench raises `start` for a second request at the very sample where it sees `done` for the first. It does this for a good request followed by a good one, and for a rejected request followed by a rejected one. It then judges both results against its own arithmetic model, including which half of the control word each one updated. A second collision, a fresh `start` during a division, is provoked mid-run with different lengths. The bench then checks that the finished result is the one from the first request.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } scl_state_e;
endpackage

// File: rtl/scl_limit_check.sv
module scl_limit_check #(
    parameter int IN_W      = 13,
    parameter int OUT_W     = 11,
    parameter int IN_LIMIT  = 4096,
    parameter int OUT_LIMIT = 1024,
    parameter int RATIO_SH  = 2
) (
    input  logic [IN_W-1:0]  src_len,
    input  logic [OUT_W-1:0] dst_len,
    output logic             bad
);
    localparam int CMP_W = ((IN_W > OUT_W + RATIO_SH) ? IN_W : OUT_W + RATIO_SH) + 1;

    logic [CMP_W-1:0] src_x;
    logic [CMP_W-1:0] dst_x;
    logic [CMP_W-1:0] dst_scaled;

    always_comb begin
        src_x      = CMP_W'(src_len);
        dst_x      = CMP_W'(dst_len);
        dst_scaled = dst_x << RATIO_SH;
        bad = (src_x == '0)
           || (src_x > CMP_W'(IN_LIMIT))
           || (dst_x < CMP_W'(2))
           || (dst_x > CMP_W'(OUT_LIMIT))
           || (dst_scaled < src_x);
    end
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int IN_W      = 13,
    parameter int OUT_W     = 11,
    parameter int OUT_LIMIT = 1024,
    parameter int HALVE_MAX = 2,
    parameter int CODE_W    = 2
) (
    input  logic [IN_W-1:0]   src_len,
    input  logic [OUT_W-1:0]  dst_len,
    output logic [IN_W-1:0]   len_half,
    output logic [CODE_W-1:0] code
);
    localparam int CMP_W = ((IN_W > OUT_W + 1) ? IN_W : OUT_W + 1) + 1;

    logic [CMP_W-1:0] work;
    logic [CMP_W-1:0] twice_dst;

    always_comb begin
        work      = CMP_W'(src_len);
        twice_dst = CMP_W'(dst_len) << 1;
        code      = '0;
        for (int i = 0; i < HALVE_MAX; i++) begin
            if ((work > CMP_W'(OUT_LIMIT)) || (work >= twice_dst)) begin
                work = work >> 1;
                code = code + CODE_W'(1);
            end
        end
        len_half = work[IN_W-1:0];
    end
endmodule

// File: rtl/scl_step_divider.sv
module scl_step_divider #(
    parameter int DVD_W = 26,
    parameter int DVS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             running,
    output logic             finished,
    output logic [DVD_W-1:0] quotient
);
    localparam int CNT_W = $clog2(DVD_W);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [DVS_W-1:0] dvs;
        logic [DVS_W-1:0] rem;
        logic [DVD_W-1:0] quo;
    } div_reg_t;

    div_reg_t         r_q, r_d;
    logic [DVS_W:0]   trial;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        trial   = '0;
        if (!r_q.run) begin
            if (launch) begin
                r_d.run = 1'b1;
                r_d.cnt = '0;
                r_d.dvs = divisor;
                r_d.rem = '0;
                r_d.quo = dividend;
            end
        end else begin
            trial = {r_q.rem, r_q.quo[DVD_W-1]};
            if (trial >= {1'b0, r_q.dvs}) begin
                trial   = trial - {1'b0, r_q.dvs};
                r_d.quo = {r_q.quo[DVD_W-2:0], 1'b1};
            end else begin
                r_d.quo = {r_q.quo[DVD_W-2:0], 1'b0};
            end
            r_d.rem = trial[DVS_W-1:0];
            r_d.cnt = r_q.cnt + CNT_W'(1);
            if (r_q.cnt == CNT_W'(DVD_W - 1)) begin
                r_d.run = 1'b0;
                r_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign running  = r_q.run;
    assign finished = r_q.fin;
    assign quotient = r_q.quo;
endmodule

// File: rtl/scl_step_calc.sv
module scl_step_calc #(
    parameter int IN_W      = 13,
    parameter int OUT_W     = 11,
    parameter int IN_LIMIT  = 4096,
    parameter int OUT_LIMIT = 1024,
    parameter int FRAC_W    = 13,
    parameter int STEP_W    = 14,
    parameter int HALVE_MAX = 2,
    parameter int CODE_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           axis,
    input  logic [IN_W-1:0]                src_len,
    input  logic [OUT_W-1:0]               dst_len,
    output logic                           busy,
    output logic                           done,
    output logic                           err,
    output logic                           warn,
    output logic [CODE_W-1:0]              dcode,
    output logic [STEP_W-1:0]              step,
    output logic [2*(CODE_W+STEP_W)-1:0]   ctrl_word
);
    import scl_pkg::*;

    localparam int FIELD_W = CODE_W + STEP_W;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int DVD_W   = IN_W + FRAC_W;

    typedef struct packed {
        scl_state_e          st;
        logic                ax;
        logic [CODE_W-1:0]   code_pend;
        logic [CODE_W-1:0]   code;
        logic [STEP_W-1:0]   stp;
        logic [WORD_W-1:0]   word;
        logic                dn;
        logic                er;
        logic                wr;
    } top_reg_t;

    top_reg_t           r_q, r_d;
    logic               bad;
    logic [IN_W-1:0]    len_half;
    logic [CODE_W-1:0]  code_now;
    logic [DVD_W-1:0]   dividend;
    logic [OUT_W-1:0]   divisor;
    logic               div_launch;
    logic               div_run;
    logic               div_fin;
    logic [DVD_W-1:0]   div_quo;
    logic [STEP_W-1:0]  step_sat;
    logic               over;

    scl_limit_check #(
        .IN_W(IN_W), .OUT_W(OUT_W), .IN_LIMIT(IN_LIMIT),
        .OUT_LIMIT(OUT_LIMIT), .RATIO_SH(2)
    ) i_limit (
        .src_len(src_len), .dst_len(dst_len), .bad(bad)
    );

    scl_prescale #(
        .IN_W(IN_W), .OUT_W(OUT_W), .OUT_LIMIT(OUT_LIMIT),
        .HALVE_MAX(HALVE_MAX), .CODE_W(CODE_W)
    ) i_prescale (
        .src_len(src_len), .dst_len(dst_len),
        .len_half(len_half), .code(code_now)
    );

    assign dividend   = {len_half - IN_W'(1), {FRAC_W{1'b0}}};
    assign divisor    = dst_len - OUT_W'(1);
    assign div_launch = start && (r_q.st == ST_IDLE) && !bad;

    scl_step_divider #(
        .DVD_W(DVD_W), .DVS_W(OUT_W)
    ) i_div (
        .clk(clk), .rst_n(rst_n), .launch(div_launch),
        .dividend(dividend), .divisor(divisor),
        .running(div_run), .finished(div_fin), .quotient(div_quo)
    );

    assign over     = |div_quo[DVD_W-1:STEP_W];
    assign step_sat = over ? {STEP_W{1'b1}} : div_quo[STEP_W-1:0];

    always_comb begin
        r_d    = r_q;
        r_d.dn = 1'b0;
        r_d.er = 1'b0;
        r_d.wr = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (bad) begin
                        r_d.dn = 1'b1;
                        r_d.er = 1'b1;
                    end else begin
                        r_d.st        = ST_DIV;
                        r_d.ax        = axis;
                        r_d.code_pend = code_now;
                    end
                end
            end
            ST_DIV: begin
                if (div_fin) begin
                    r_d.st   = ST_IDLE;
                    r_d.dn   = 1'b1;
                    r_d.wr   = over;
                    r_d.code = r_q.code_pend;
                    r_d.stp  = step_sat;
                    if (r_q.ax) begin
                        r_d.word[WORD_W-1:FIELD_W] = {r_q.code_pend, step_sat};
                    end else begin
                        r_d.word[FIELD_W-1:0] = {r_q.code_pend, step_sat};
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_DIV) && (div_run || div_fin);
    assign done      = r_q.dn;
    assign err       = r_q.er;
    assign warn      = r_q.wr;
    assign dcode     = r_q.code;
    assign step      = r_q.stp;
    assign ctrl_word = r_q.word;
endmodule

// File: rtl/scl_step_calc_chk.sv
module scl_step_calc_chk #(
    parameter int STEP_W = 14,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              warn,
    input logic [STEP_W-1:0] step,
    input logic [WORD_W-1:0] ctrl_word
);
    assert_err_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_err_keeps_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(ctrl_word));

    assert_clamp_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> (done && !err && (step == {STEP_W{1'b1}})));

    assert_word_moves_on_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> (done && !err));

    assert_busy_excl_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind scl_step_calc scl_step_calc_chk #(
    .STEP_W(STEP_W), .WORD_W(2*(CODE_W+STEP_W))
) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .warn(warn), .step(step), .ctrl_word(ctrl_word)
);

// File: tb/test_scl_step_calc.sv
module test_scl_step_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        axis = 1'b0;
    logic [12:0] src_len = '0;
    logic [10:0] dst_len = '0;
    logic        busy, done, err, warn;
    logic [1:0]  dcode;
    logic [13:0] step;
    logic [31:0] ctrl_word;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_word = '0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    scl_step_calc i_scl_step_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .axis(axis),
        .src_len(src_len), .dst_len(dst_len), .busy(busy), .done(done),
        .err(err), .warn(warn), .dcode(dcode), .step(step), .ctrl_word(ctrl_word)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input int in, input int out, output bit e, output int c,
                         output int s, output bit w);
        int h;
        longint q;
        e = (in == 0) || (in > 4096) || (out < 2) || (out > 1024) || (out * 4 < in);
        c = 0; s = 0; w = 1'b0;
        if (!e) begin
            h = in;
            for (int i = 0; i < 2; i++) begin
                if ((h > 1024) || (h >= 2 * out)) begin
                    h = h / 2;
                    c++;
                end
            end
            q = (64'(8192) * (h - 1)) / (out - 1);
            if (q >= 16384) begin
                s = 16383; w = 1'b1;
            end else begin
                s = int'(q);
            end
        end
    endtask

    task automatic launch(input int in, input int out, input bit ax);
        @(negedge clk);
        src_len = 13'(in); dst_len = 11'(out); axis = ax; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R8 done never seen", 0, 1);
    endtask

    task automatic judge(input int in, input int out, input bit ax);
        bit e, w;
        int c, s;
        model(in, out, e, c, s, w);
        chk(err == e, $sformatf("R1/R2/R3 err in=%0d out=%0d", in, out), err, e);
        if (!e) begin
            if (ax) exp_word[31:16] = {2'(c), 14'(s)};
            else    exp_word[15:0]  = {2'(c), 14'(s)};
            chk(dcode == 2'(c), $sformatf("R4 code in=%0d out=%0d", in, out), dcode, c);
            chk(step == 14'(s), $sformatf("R5 step in=%0d out=%0d", in, out), step, s);
            chk(warn == w, $sformatf("R6 warn in=%0d out=%0d", in, out), warn, w);
        end else begin
            chk(!warn, "R6 warn on rejected request", warn, 0);
        end
        chk(ctrl_word == exp_word, $sformatf("R7 word in=%0d out=%0d", in, out),
            ctrl_word, exp_word);
    endtask

    task automatic run(input int in, input int out, input bit ax);
        launch(in, out, ax);
        wait_done();
        judge(in, out, ax);
    endtask

    initial begin
        int n = 0;
        while (!finished && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=finish", n);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!done && !busy && !err && !warn, "R10 flags after reset", {done, busy, err, warn}, 0);
        chk(ctrl_word == 32'h0, "R10 word after reset", ctrl_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: rejected request finishes one cycle after start
        launch(5000, 100, 1'b0);
        chk(done && err, "R8 rejected latency", {done, err}, 2'b11);
        judge(5000, 100, 1'b0);

        // Boundaries for R1, R2, R3, R4, R5
        run(4096, 1024, 1'b1);
        run(4097, 1024, 1'b0);
        run(4096, 1023, 1'b1);
        run(2048, 1025, 1'b0);
        run(1024, 1024, 1'b0);
        run(1, 1024, 1'b1);
        run(4000, 1000, 1'b0);
        run(8191, 2047, 1'b1);
        run(3, 2, 1'b0);
        run(100, 1, 1'b1);
        run(1025, 300, 1'b1);

        // Near-exhaustive sweep over small lengths, alternating axis
        for (int o = 0; o <= 20; o++) begin
            for (int i = 0; i <= 90; i++) begin
                run(i, o, 1'(i + o));
            end
        end

        // R9: start during a division is ignored
        launch(60, 17, 1'b1);
        chk(busy, "R8 busy during division", busy, 1);
        repeat (4) @(negedge clk);
        src_len = 13'd9; dst_len = 11'd2; axis = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        src_len = 13'd0;
        wait_done();
        judge(60, 17, 1'b1);
        @(negedge clk);
        chk(!done && !busy, "R9 no second result", {done, busy}, 0);

        // R11: back-to-back good requests
        launch(77, 33, 1'b0);
        wait_done();
        src_len = 13'd500; dst_len = 11'd999; axis = 1'b1; start = 1'b1;
        judge(77, 33, 1'b0);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 second request accepted", busy, 1);
        wait_done();
        judge(500, 999, 1'b1);

        // R11: back-to-back rejected requests
        launch(10, 0, 1'b1);
        chk(done, "R11 first reject done", done, 1);
        src_len = 13'd0; dst_len = 11'd5; axis = 1'b0; start = 1'b1;
        judge(10, 0, 1'b1);
        @(negedge clk);
        start = 1'b0;
        chk(done && err, "R11 second reject done", {done, err}, 2'b11);
        judge(0, 5, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule